// File: doc/BRIEF.md
# Framebuffer Rectangle Copy and Clear Engine

This block moves a rectangular region of the on-chip frame buffer out to external memory. A start pulse loads the programmed copy settings into the block. The block then visits every pixel of the rectangle, one per cycle. For each pixel it issues a read of the source location and, in the same cycle, a write of that pixel to the destination address in external memory. The pixel word passes through unchanged. Colour conversion, filtering and scaling are done elsewhere.

The destination is a base address plus a row pitch. The base register holds the byte address divided by 32, and the pitch counts 32-byte units. An optional clear runs in the same pass: each visited frame-buffer location is overwritten with a programmed colour and depth in the cycle it is read. A stall input holds the walk without losing position. A done flag reports that the last pixel has gone out.

Top module: `fb_copy_engine`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o, src_rd_o, dst_wr_o and clr_wr_o are all low until a start is accepted.
- R2: The origin register carries X in bits 9:0 and Y in bits 19:10. The size register carries width minus one in bits 9:0 and height minus one in bits 19:10. One copy issues exactly (width)×(height) pixels.
- R3: Pixels are visited row-major: left to right, then top to bottom. The source coordinate is the origin plus the column and row offsets, modulo 1024 on each axis.
- R4: The destination address of a pixel is (base<<5) + row×(stride[9:0]<<5) + column×4. Bits 23:10 of the stride register are ignored.
- R5: dst_wr_o is asserted in the same cycle as src_rd_o, and dst_data_o equals src_data_i in that cycle.
- R6: With clearing enabled, clr_wr_o accompanies every source read at the same coordinate. The clear colour is {alpha, red, green, blue}: alpha and red come from bits 15:8 and 7:0 of the first colour register, and green and blue come from bits 15:8 and 7:0 of the second. Depth is the 24-bit depth register.
- R7: With clearing disabled, clr_wr_o stays low for the whole copy.
- R8: While stall_i is high, no strobe is asserted and the walk position does not advance.
- R9: done_o rises in the cycle after the last pixel is issued, together with busy_o falling. It holds until the next accepted start, which clears it in the following cycle.
- R10: A start while busy is ignored. The settings are captured at the accepted start, so later register changes do not affect the running copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| stall_i | input | 1 | Hold the walk this cycle |
| box_origin_i | input | 24 | Rectangle origin: X in 9:0, Y in 19:10 |
| box_size_i | input | 24 | Width-1 in 9:0, height-1 in 19:10 |
| dst_base_i | input | 24 | Destination byte address shifted right by 5 |
| dst_stride_i | input | 24 | Row pitch in 32-byte units, bits 9:0 used |
| clr_en_i | input | 1 | Enable clear during the copy |
| clr_ar_i | input | 24 | Alpha in 15:8, red in 7:0 |
| clr_gb_i | input | 24 | Green in 15:8, blue in 7:0 |
| clr_depth_i | input | 24 | Clear depth, 0 = 0.0, all ones = 1.0 |
| src_data_i | input | 32 | Pixel word returned by the frame buffer, same cycle |
| src_rd_o | output | 1 | Source read strobe |
| src_x_o | output | 10 | Source X |
| src_y_o | output | 10 | Source Y |
| dst_wr_o | output | 1 | Destination write strobe |
| dst_addr_o | output | 32 | Destination byte address |
| dst_data_o | output | 32 | Destination pixel word |
| clr_wr_o | output | 1 | Clear write strobe |
| clr_x_o | output | 10 | Clear X |
| clr_y_o | output | 10 | Clear Y |
| clr_color_o | output | 32 | Clear colour {A,R,G,B} |
| clr_depth_o | output | 24 | Clear depth |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | Last copy finished |

## Verification
The assertions assume that the frame buffer returns src_data_i combinationally in the cycle of the read. They also assume that stall_i only matters while busy, and that reset is asserted at time zero. The bench derives src_data_i from the requested coordinate in the same cycle. It changes inputs only shortly after a rising edge. Stall bursts and a rogue start pulse are applied only while a copy is running, so every other cycle of the walk remains a plain one-pixel step.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  parameter int unsigned REG_W      = 24;
  parameter int unsigned COORD_W    = 10;
  parameter int unsigned STRIDE_W   = 10;
  parameter int unsigned ADDR_W     = 32;
  parameter int unsigned ADDR_SHIFT = 5;
  parameter int unsigned PX_BYTES   = 4;
  parameter int unsigned CH_W       = 8;
  parameter int unsigned N_CH       = 4;
  parameter int unsigned DEPTH_W    = 24;
  parameter int unsigned PX_W       = 32;

  localparam int unsigned PX_SHIFT = $clog2(PX_BYTES);
  localparam int unsigned COLOR_W  = N_CH * CH_W;

  typedef struct packed {
    logic [COORD_W-1:0] org_x;
    logic [COORD_W-1:0] org_y;
    logic [COORD_W-1:0] last_col;
    logic [COORD_W-1:0] last_row;
    logic [ADDR_W-1:0]  base_addr;
    logic [ADDR_W-1:0]  row_step;
    logic               clr_en;
    logic [COLOR_W-1:0] clr_color;
    logic [DEPTH_W-1:0] clr_depth;
  } copy_cfg_t;
endpackage

// File: rtl/fbc_cfg_unpack.sv
module fbc_cfg_unpack
  import fbc_pkg::*;
(
  input  logic [REG_W-1:0] box_origin_i,
  input  logic [REG_W-1:0] box_size_i,
  input  logic [REG_W-1:0] dst_base_i,
  input  logic [REG_W-1:0] dst_stride_i,
  input  logic             clr_en_i,
  input  logic [REG_W-1:0] clr_ar_i,
  input  logic [REG_W-1:0] clr_gb_i,
  input  logic [REG_W-1:0] clr_depth_i,
  output copy_cfg_t        cfg_o
);
  // channel order on the output word: alpha, red, green, blue (msb first)
  logic [CH_W-1:0] chan [N_CH];

  assign chan[0] = clr_gb_i[CH_W-1:0];       // blue
  assign chan[1] = clr_gb_i[2*CH_W-1:CH_W];  // green
  assign chan[2] = clr_ar_i[CH_W-1:0];       // red
  assign chan[3] = clr_ar_i[2*CH_W-1:CH_W];  // alpha

  logic [COLOR_W-1:0] color;
  for (genvar c = 0; c < N_CH; c++) begin : g_pack
    assign color[c*CH_W +: CH_W] = chan[c];
  end

  always_comb begin
    cfg_o.org_x     = box_origin_i[COORD_W-1:0];
    cfg_o.org_y     = box_origin_i[2*COORD_W-1:COORD_W];
    cfg_o.last_col  = box_size_i[COORD_W-1:0];
    cfg_o.last_row  = box_size_i[2*COORD_W-1:COORD_W];
    cfg_o.base_addr = ADDR_W'(dst_base_i) << ADDR_SHIFT;
    cfg_o.row_step  = ADDR_W'(dst_stride_i[STRIDE_W-1:0]) << ADDR_SHIFT;
    cfg_o.clr_en    = clr_en_i;
    cfg_o.clr_color = color;
    cfg_o.clr_depth = clr_depth_i[DEPTH_W-1:0];
  end
endmodule

// File: rtl/fbc_walker.sv
module fbc_walker
  import fbc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stall_i,
  input  copy_cfg_t          cfg_i,
  output copy_cfg_t          cfg_o,
  output logic [COORD_W-1:0] col_o,
  output logic [COORD_W-1:0] row_o,
  output logic               accept_o,
  output logic               issue_o,
  output logic               row_adv_o,
  output logic               busy_o,
  output logic               done_o
);
  copy_cfg_t          cfg_q;
  logic [COORD_W-1:0] col_q, row_q;
  logic               busy_q, done_q;
  logic               at_eol, at_eof;

  assign accept_o  = start_i & ~busy_q;
  assign issue_o   = busy_q & ~stall_i;
  assign at_eol    = (col_q == cfg_q.last_col);
  assign at_eof    = at_eol & (row_q == cfg_q.last_row);
  assign row_adv_o = issue_o & at_eol & ~at_eof;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      col_q  <= '0;
      row_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept_o) begin
      cfg_q  <= cfg_i;
      col_q  <= '0;
      row_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (issue_o) begin
      if (at_eol) begin
        col_q <= '0;
        if (at_eof) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign col_o  = col_q;
  assign row_o  = row_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/fbc_addr_gen.sv
module fbc_addr_gen
  import fbc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic               row_adv_i,
  input  logic [ADDR_W-1:0]  start_base_i,
  input  copy_cfg_t          cfg_i,
  input  logic [COORD_W-1:0] col_i,
  input  logic [COORD_W-1:0] row_i,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o,
  output logic [ADDR_W-1:0]  dst_addr_o
);
  // row base accumulates stride so no multiplier sits on the address path
  logic [ADDR_W-1:0] row_base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        row_base_q <= '0;
    else if (accept_i)  row_base_q <= start_base_i;
    else if (row_adv_i) row_base_q <= row_base_q + cfg_i.row_step;
  end

  assign x_o        = cfg_i.org_x + col_i;
  assign y_o        = cfg_i.org_y + row_i;
  assign dst_addr_o = row_base_q + (ADDR_W'(col_i) << PX_SHIFT);
endmodule

// File: rtl/fbc_clear_gen.sv
module fbc_clear_gen
  import fbc_pkg::*;
(
  input  logic               issue_i,
  input  copy_cfg_t          cfg_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic               clr_wr_o,
  output logic [COORD_W-1:0] clr_x_o,
  output logic [COORD_W-1:0] clr_y_o,
  output logic [COLOR_W-1:0] clr_color_o,
  output logic [DEPTH_W-1:0] clr_depth_o
);
  assign clr_wr_o    = issue_i & cfg_i.clr_en;
  assign clr_x_o     = x_i;
  assign clr_y_o     = y_i;
  assign clr_color_o = cfg_i.clr_color;
  assign clr_depth_o = cfg_i.clr_depth;
endmodule

// File: rtl/fb_copy_engine.sv
module fb_copy_engine
  import fbc_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     stall_i,
  input  logic [REG_W-1:0]         box_origin_i,
  input  logic [REG_W-1:0]         box_size_i,
  input  logic [REG_W-1:0]         dst_base_i,
  input  logic [REG_W-1:0]         dst_stride_i,
  input  logic                     clr_en_i,
  input  logic [REG_W-1:0]         clr_ar_i,
  input  logic [REG_W-1:0]         clr_gb_i,
  input  logic [REG_W-1:0]         clr_depth_i,
  input  logic [PX_W-1:0]          src_data_i,
  output logic                     src_rd_o,
  output logic [COORD_W-1:0]       src_x_o,
  output logic [COORD_W-1:0]       src_y_o,
  output logic                     dst_wr_o,
  output logic [ADDR_W-1:0]        dst_addr_o,
  output logic [PX_W-1:0]          dst_data_o,
  output logic                     clr_wr_o,
  output logic [COORD_W-1:0]       clr_x_o,
  output logic [COORD_W-1:0]       clr_y_o,
  output logic [COLOR_W-1:0]       clr_color_o,
  output logic [DEPTH_W-1:0]       clr_depth_o,
  output logic                     busy_o,
  output logic                     done_o
);
  copy_cfg_t          cfg_raw, cfg_run;
  logic [COORD_W-1:0] col, row, px_x, px_y;
  logic               accept, issue, row_adv;

  fbc_cfg_unpack u_unpack (
    .box_origin_i (box_origin_i),
    .box_size_i   (box_size_i),
    .dst_base_i   (dst_base_i),
    .dst_stride_i (dst_stride_i),
    .clr_en_i     (clr_en_i),
    .clr_ar_i     (clr_ar_i),
    .clr_gb_i     (clr_gb_i),
    .clr_depth_i  (clr_depth_i),
    .cfg_o        (cfg_raw)
  );

  fbc_walker u_walker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stall_i   (stall_i),
    .cfg_i     (cfg_raw),
    .cfg_o     (cfg_run),
    .col_o     (col),
    .row_o     (row),
    .accept_o  (accept),
    .issue_o   (issue),
    .row_adv_o (row_adv),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  fbc_addr_gen u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .row_adv_i    (row_adv),
    .start_base_i (cfg_raw.base_addr),
    .cfg_i        (cfg_run),
    .col_i        (col),
    .row_i        (row),
    .x_o          (px_x),
    .y_o          (px_y),
    .dst_addr_o   (dst_addr_o)
  );

  fbc_clear_gen u_clear (
    .issue_i     (issue),
    .cfg_i       (cfg_run),
    .x_i         (px_x),
    .y_i         (px_y),
    .clr_wr_o    (clr_wr_o),
    .clr_x_o     (clr_x_o),
    .clr_y_o     (clr_y_o),
    .clr_color_o (clr_color_o),
    .clr_depth_o (clr_depth_o)
  );

  assign src_rd_o   = issue;
  assign src_x_o    = px_x;
  assign src_y_o    = px_y;
  assign dst_wr_o   = issue;
  assign dst_data_o = src_data_i;
endmodule

// File: rtl/fbc_copy_checker.sv
module fbc_copy_checker
  import fbc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               stall_i,
  input logic [PX_W-1:0]    src_data_i,
  input logic               src_rd_o,
  input logic [COORD_W-1:0] src_x_o,
  input logic [COORD_W-1:0] src_y_o,
  input logic               dst_wr_o,
  input logic [PX_W-1:0]    dst_data_o,
  input logic               clr_wr_o,
  input logic [COORD_W-1:0] clr_x_o,
  input logic [COORD_W-1:0] clr_y_o,
  input logic               busy_o,
  input logic               done_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!busy_o && !done_o && !src_rd_o && !clr_wr_o);
    end
  end

  assert_row_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_rd_o && $past(src_rd_o) && src_y_o == $past(src_y_o))
      |-> src_x_o == COORD_W'($past(src_x_o) + 1'b1));

  assert_pass_through_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_rd_o |-> (dst_wr_o && dst_data_o == src_data_i));

  assert_clear_colocated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_o |-> (src_rd_o && clr_x_o == src_x_o && clr_y_o == src_y_o));

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stall_i) |=> ($stable(src_x_o) && $stable(src_y_o) && busy_o));

  assert_done_on_finish_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !src_rd_o) |=> busy_o);
endmodule

bind fb_copy_engine fbc_copy_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .stall_i    (stall_i),
  .src_data_i (src_data_i),
  .src_rd_o   (src_rd_o),
  .src_x_o    (src_x_o),
  .src_y_o    (src_y_o),
  .dst_wr_o   (dst_wr_o),
  .dst_data_o (dst_data_o),
  .clr_wr_o   (clr_wr_o),
  .clr_x_o    (clr_x_o),
  .clr_y_o    (clr_y_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/fb_copy_engine_bench.sv
module fb_copy_engine_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [9:0]  x;
    logic [9:0]  y;
    logic [31:0] addr;
    bit          last;
  } exp_px_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        stall_i = 1'b0;
  logic [23:0] box_origin_i = '0, box_size_i = '0, dst_base_i = '0, dst_stride_i = '0;
  logic        clr_en_i = 1'b0;
  logic [23:0] clr_ar_i = '0, clr_gb_i = '0, clr_depth_i = '0;
  logic [31:0] src_data_i;
  logic        src_rd_o, dst_wr_o, clr_wr_o, busy_o, done_o;
  logic [9:0]  src_x_o, src_y_o, clr_x_o, clr_y_o;
  logic [31:0] dst_addr_o, dst_data_o, clr_color_o;
  logic [23:0] clr_depth_o;

  int errors = 0;
  int checks = 0;
  exp_px_t exp_q[$];
  bit      exp_clr;
  logic [31:0] exp_color;
  logic [23:0] exp_depth;
  bit      pending_done = 0;
  bit      finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // frame buffer model: pixel word derived from coordinate
  assign src_data_i = {src_y_o, src_x_o, 12'hC35};

  fb_copy_engine u_fb_copy_engine (.*);

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (pending_done) begin
          check(done_o && !busy_o, "R9", "done after last pixel", {done_o, busy_o}, 2'b10);
          pending_done = 0;
        end
        if (stall_i && busy_o)
          check(!src_rd_o && !dst_wr_o && !clr_wr_o, "R8", "strobes in stall",
                {src_rd_o, dst_wr_o, clr_wr_o}, 0);
        if (src_rd_o) begin
          if (exp_q.size() == 0) begin
            check(0, "R10", "unexpected pixel", {src_y_o, src_x_o}, 0);
          end else begin
            exp_px_t e;
            e = exp_q.pop_front();
            check(src_x_o == e.x && src_y_o == e.y, "R3", "source coord",
                  {src_y_o, src_x_o}, {e.y, e.x});
            check(dst_addr_o == e.addr, "R4", "dest address", dst_addr_o, e.addr);
            check(dst_wr_o && dst_data_o == src_data_i, "R5", "pass-through",
                  {dst_wr_o, dst_data_o}, {1'b1, src_data_i});
            if (exp_clr) begin
              check(clr_wr_o && clr_x_o == e.x && clr_y_o == e.y, "R6", "clear strobe",
                    {clr_wr_o, clr_y_o, clr_x_o}, {1'b1, e.y, e.x});
              check(clr_color_o == exp_color && clr_depth_o == exp_depth, "R6", "clear value",
                    {clr_color_o, clr_depth_o}, {exp_color, exp_depth});
            end else begin
              check(!clr_wr_o, "R7", "clear disabled", clr_wr_o, 0);
            end
            check(!done_o, "R9", "done low while issuing", done_o, 0);
            if (e.last) pending_done = 1;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      check(0, "watchdog", "timeout", 0, 1);
      report();
    end
  end

  task automatic run_copy(
    input logic [9:0] ox, input logic [9:0] oy,
    input logic [9:0] wm1, input logic [9:0] hm1,
    input logic [23:0] base, input logic [23:0] stride,
    input bit clr, input logic [7:0] a, input logic [7:0] r,
    input logic [7:0] g, input logic [7:0] b, input logic [23:0] depth,
    input bit do_stall, input bit rogue_start);
    logic [31:0] row_base;
    int cyc;
    @(posedge clk_i); #1;
    box_origin_i = {4'h5, oy, ox};
    box_size_i   = {4'hA, hm1, wm1};
    dst_base_i   = base;
    dst_stride_i = stride;
    clr_en_i     = clr;
    clr_ar_i     = {8'h77, a, r};
    clr_gb_i     = {8'h99, g, b};
    clr_depth_i  = depth;
    exp_clr   = clr;
    exp_color = {a, r, g, b};
    exp_depth = depth;
    row_base  = {3'b0, base, 5'b0};
    for (int y = 0; y <= int'(hm1); y++) begin
      for (int x = 0; x <= int'(wm1); x++) begin
        exp_px_t e;
        e.x = ox + 10'(x);
        e.y = oy + 10'(y);
        e.addr = row_base + 32'(x) * 4;
        e.last = (x == int'(wm1)) && (y == int'(hm1));
        exp_q.push_back(e);
      end
      row_base = row_base + ({22'b0, stride[9:0]} << 5);
    end
    start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    // R10: settings captured at start, later edits must not matter
    box_origin_i = 24'h0;
    dst_base_i   = 24'h3;
    clr_en_i     = ~clr;
    clr_ar_i     = 24'h0;
    @(negedge clk_i);
    check(busy_o && !done_o, "R9", "start clears done", {busy_o, done_o}, 2'b10);
    cyc = 0;
    while (busy_o && cyc < 5000) begin
      @(posedge clk_i); #1;
      cyc++;
      stall_i = do_stall && (cyc % 3 == 1);
      start_i = rogue_start && (cyc == 2);
      if (rogue_start && cyc == 2) box_size_i = 24'h0;
    end
    stall_i = 1'b0;
    start_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    check(exp_q.size() == 0, "R2", "pixel count", exp_q.size(), 0);
    check(done_o && !busy_o, "R9", "done holds", {done_o, busy_o}, 2'b10);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(!busy_o && !done_o && !src_rd_o && !dst_wr_o && !clr_wr_o, "R1", "reset state",
          {busy_o, done_o, src_rd_o, dst_wr_o, clr_wr_o}, 0);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !src_rd_o, "R1", "idle after reset",
          {busy_o, done_o, src_rd_o}, 0);

    // R2 R4 R6: multi-row, stride with junk in upper bits
    run_copy(10'd5, 10'd7, 10'd3, 10'd2, 24'h000080, {14'h2AB, 10'd40},
             1, 8'hF1, 8'h12, 8'h34, 8'h56, 24'hFFFFFF, 0, 0);
    // R2 single pixel, R7 clear off
    run_copy(10'd1023, 10'd1023, 10'd0, 10'd0, 24'h012345, 24'd1,
             0, 8'h0, 8'h0, 8'h0, 8'h0, 24'h0, 0, 0);
    // R3 wrap across X and Y
    run_copy(10'd1022, 10'd1023, 10'd2, 10'd1, 24'h000010, 24'd3,
             1, 8'h01, 8'h02, 8'h03, 8'h04, 24'h000000, 0, 0);
    // R8 stalls and R10 rogue start while busy
    run_copy(10'd100, 10'd200, 10'd7, 10'd3, 24'h00ABCD, 24'd1023,
             1, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 24'h7FFFFF, 1, 1);
    // back-to-back: R7 on a wide row with stall
    run_copy(10'd0, 10'd0, 10'd15, 10'd0, 24'hFFFFFF, 24'd0,
             0, 8'h0, 8'h0, 8'h0, 8'h0, 24'h0, 1, 0);

    finished = 1;
    report();
  end
endmodule